// File: doc/BRIEF.md
# Edge-Counted Glitch Pulse Generator

This block times a single fault-injection event against an external trigger. Software feeds it three 32-bit words through a valid/ready parameter stream: an edge count, a pulse offset and a pulse width. The block counts rising edges on an asynchronous trigger input, which it first resynchronises, then waits out the offset and drives the pulse for the width. A second output bit disables a capacitor bank from the start of the offset until a fixed hold time after the pulse, so the glitch has fully landed before the capacitors return.

The two outputs travel together as `glitch_out = {caps_disable, pulse}`. When the hold ends, the block returns the outputs to rest, raises `done` and waits for `done_ack` before it will accept a new edge count. Back-pressure on the parameter stream works as follows. `param_ready` is high only in the three states where a word is expected. A word transfers on any clock edge where `param_valid` and `param_ready` are both high. While `param_valid` is low in such a state, the block stalls there and its outputs keep their present value. The width word is taken only after the last edge has been counted.

Every count runs at the full clock rate and is tested before it is decremented. A synchronous `abort` input returns the block to rest at any time.

Top module: `glitch_pulse_gen`

## Requirements
- R1: Parameter words are accepted in this order: edge count, then offset, then width. `param_ready` is low from the acceptance of the offset until the last edge has been counted, so a queued width word waits.
- R2: An edge counts only after the synchronised trigger has been low and then high. A trigger that is already high when counting begins must fall before its rise can count.
- R3: A loaded value N gives N+1 counted edges, N+1 offset cycles (`glitch_out` = 2'b10) and N+1 width cycles (`glitch_out` = 2'b11).
- R4: The output encoding is `glitch_out` = {caps_disable, pulse}. It is 2'b00 at rest, while loading and while counting edges; 2'b10 during offset and hold; 2'b11 during width. The value 2'b01 never appears.
- R5: After the width phase `glitch_out` stays at 2'b10 for exactly 1313 cycles (1 + 32×41) and then returns to 2'b00.
- R6: `done` rises on the cycle `glitch_out` returns to 2'b00 after the hold. The block then stays there until `done_ack` is sampled high, and afterwards it asserts `param_ready` for a new edge count.
- R7: `done` stays set after the acknowledgement. It clears on the edge that accepts the next offset word.
- R8: When `param_valid` is low in a state that expects a word, the state and `glitch_out` hold unchanged.
- R9: `busy` is low only while the block waits for an edge count word.
- R10: `abort` sampled high forces `glitch_out` to 2'b00, clears `done` and returns the block to waiting for an edge count on the next cycle.
- R11: When the width word is already waiting, `glitch_out` changes from 2'b00 to 2'b10 on the fourth rising clock edge after the final trigger rise at the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Synchronous return to rest; clears `done` |
| param_valid | input | 1 | Parameter word present on `param_data` |
| param_ready | output | 1 | Block accepts a parameter word this cycle |
| param_data | input | 32 | Edge count, offset or width word |
| trig_in | input | 1 | Asynchronous trigger; its rising edges are counted |
| done_ack | input | 1 | Releases the block from its completion wait |
| glitch_out | output | 2 | {caps_disable, pulse} |
| busy | output | 1 | High except while waiting for an edge count word |
| done | output | 1 | Completion flag, sticky until the next offset word is accepted |

## Verification
The bench starts counting with the trigger already high. A design that counted that level as an edge would fire one edge early. The width word is withheld after the last edge, so a design that ignored the empty stream would start the offset phase without it. A second test queues the width word before the edges, so a design that took it early would treat it as the offset or the edge count. A cycle-by-cycle reference model catches off-by-one counting in the offset, width and 1313-cycle hold phases. It also catches a wrong synchroniser depth, which shows up as a shifted latency. The `done` flag is followed through the acknowledgement and the next parameter load, so a design that cleared it on the acknowledgement alone, or never cleared it, is reported. An abort in the middle of the offset phase shows whether `glitch_out` and `done` really return to rest.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [3:0] {
    ST_LOAD_EDGES,
    ST_LOAD_OFFSET,
    ST_SEEK_LOW,
    ST_SEEK_HIGH,
    ST_LOAD_WIDTH,
    ST_OFFSET,
    ST_WIDTH,
    ST_HOLD,
    ST_DONE
  } gp_state_e;

  localparam logic [1:0] GP_OUT_REST = 2'b00;
  localparam logic [1:0] GP_OUT_CAPS = 2'b10;
  localparam logic [1:0] GP_OUT_FIRE = 2'b11;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("gp_sync needs at least two stages");
  end
endmodule

// File: rtl/gp_down_counter.sv
module gp_down_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);

  // R3: test-then-decrement means a zero count is never decremented
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !is_zero);
endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
  import gp_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_SETUP    = 1,
  parameter int HOLD_ITERS    = 32,
  parameter int HOLD_ITER_LEN = 41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              param_valid,
  output logic              param_ready,
  input  logic [DATA_W-1:0] param_data,
  input  logic              trig_in,
  input  logic              done_ack,
  output logic [1:0]        glitch_out,
  output logic              busy,
  output logic              done
);
  localparam int HOLD_CYCLES = HOLD_SETUP + HOLD_ITERS * HOLD_ITER_LEN;
  localparam int HOLD_W      = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);

  gp_state_e state, nxt;
  logic trig_s, hs;
  logic ld_cnt, dec_cnt, cnt_zero;
  logic ld_ofs, dec_ofs, ofs_zero;
  logic ld_hold, dec_hold, hold_zero;
  logic set_done, clr_done;

  gp_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
  );

  // shared by edge count and width: the two never overlap in time
  gp_down_counter #(.W(DATA_W)) u_main_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_cnt), .load_val(param_data),
    .dec(dec_cnt), .is_zero(cnt_zero)
  );

  gp_down_counter #(.W(DATA_W)) u_ofs_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_ofs), .load_val(param_data),
    .dec(dec_ofs), .is_zero(ofs_zero)
  );

  gp_down_counter #(.W(HOLD_W)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_hold), .load_val(HOLD_LOAD),
    .dec(dec_hold), .is_zero(hold_zero)
  );

  always_comb begin
    unique case (state)
      ST_LOAD_EDGES, ST_LOAD_OFFSET, ST_LOAD_WIDTH: param_ready = 1'b1;
      default:                                      param_ready = 1'b0;
    endcase
  end

  assign hs = param_valid && param_ready;

  always_comb begin
    nxt      = state;
    ld_cnt   = 1'b0;
    dec_cnt  = 1'b0;
    ld_ofs   = 1'b0;
    dec_ofs  = 1'b0;
    ld_hold  = 1'b0;
    dec_hold = 1'b0;
    set_done = 1'b0;
    clr_done = 1'b0;
    unique case (state)
      ST_LOAD_EDGES: if (hs) begin
        ld_cnt = 1'b1;
        nxt    = ST_LOAD_OFFSET;
      end
      ST_LOAD_OFFSET: if (hs) begin
        ld_ofs   = 1'b1;
        clr_done = 1'b1;
        nxt      = ST_SEEK_LOW;
      end
      ST_SEEK_LOW: if (!trig_s) nxt = ST_SEEK_HIGH;
      ST_SEEK_HIGH: if (trig_s) begin
        if (cnt_zero) nxt = ST_LOAD_WIDTH;
        else begin
          dec_cnt = 1'b1;
          nxt     = ST_SEEK_LOW;
        end
      end
      ST_LOAD_WIDTH: if (hs) begin
        ld_cnt = 1'b1;
        nxt    = ST_OFFSET;
      end
      ST_OFFSET: begin
        if (ofs_zero) nxt = ST_WIDTH;
        else          dec_ofs = 1'b1;
      end
      ST_WIDTH: begin
        if (cnt_zero) begin
          ld_hold = 1'b1;
          nxt     = ST_HOLD;
        end else dec_cnt = 1'b1;
      end
      ST_HOLD: begin
        if (hold_zero) begin
          set_done = 1'b1;
          nxt      = ST_DONE;
        end else dec_hold = 1'b1;
      end
      ST_DONE: if (done_ack) nxt = ST_LOAD_EDGES;
      default: nxt = ST_LOAD_EDGES;
    endcase
    if (abort) nxt = ST_LOAD_EDGES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOAD_EDGES;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 done <= 1'b0;
    else if (abort || clr_done) done <= 1'b0;
    else if (set_done)          done <= 1'b1;
  end

  always_comb begin
    unique case (state)
      ST_OFFSET, ST_HOLD: glitch_out = GP_OUT_CAPS;
      ST_WIDTH:           glitch_out = GP_OUT_FIRE;
      default:            glitch_out = GP_OUT_REST;
    endcase
  end

  assign busy = (state != ST_LOAD_EDGES);

  // R4: pulse never fires without the capacitor bank disabled
  p_no_bare_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_out != 2'b01);

  // R1: words are only taken while the outputs are at rest
  p_ready_at_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    param_ready |-> (glitch_out == GP_OUT_REST));

  // R6: completion follows the hold phase directly
  p_done_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(glitch_out) == GP_OUT_CAPS && glitch_out == GP_OUT_REST));

  // R7: accepting the offset word clears the flag
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD_OFFSET && param_valid) |=> !done);

  // R8: empty stream stalls the block
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (param_ready && !param_valid && !abort) |=> ($stable(state) && $stable(glitch_out)));

  // R10: abort returns everything to rest
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (glitch_out == GP_OUT_REST && !done && !busy));
endmodule

// File: tb/glitch_pulse_gen_tb_top.sv
module glitch_pulse_gen_tb_top;
  localparam int HOLD = 1313;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort = 1'b0;
  logic        param_valid = 1'b0;
  logic [31:0] param_data = '0;
  logic        trig = 1'b0;
  logic        done_ack = 1'b0;
  logic        param_ready, busy, done;
  logic [1:0]  glitch_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] q[$];

  always #10 clk = ~clk;

  glitch_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .abort(abort), .param_valid(param_valid),
    .param_ready(param_ready), .param_data(param_data), .trig_in(trig),
    .done_ack(done_ack), .glitch_out(glitch_out), .busy(busy), .done(done)
  );

  // behavioural reference
  int          ph = 0;
  logic [31:0] m_cnt = '0;
  logic [31:0] m_ofs = '0;
  int          m_hold = 0;
  logic        m_done = 1'b0;
  logic        s1 = 1'b0;
  logic        s2 = 1'b0;
  logic        m_rdy, m_take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_done = 1'b0; s1 = 1'b0; s2 = 1'b0;
    end else begin
      m_rdy  = (ph == 0 || ph == 1 || ph == 4);
      m_take = m_rdy && param_valid;
      if (m_take && q.size() > 0) void'(q.pop_front());
      if (abort) begin
        ph = 0; m_done = 1'b0;
      end else begin
        case (ph)
          0: if (m_take) begin m_cnt = param_data; ph = 1; end
          1: if (m_take) begin m_ofs = param_data; m_done = 1'b0; ph = 2; end
          2: if (!s2) ph = 3;
          3: if (s2) begin
               if (m_cnt == 0) ph = 4;
               else begin m_cnt = m_cnt - 1; ph = 2; end
             end
          4: if (m_take) begin m_cnt = param_data; ph = 5; end
          5: if (m_ofs == 0) ph = 6; else m_ofs = m_ofs - 1;
          6: if (m_cnt == 0) begin ph = 7; m_hold = HOLD - 1; end
             else m_cnt = m_cnt - 1;
          7: if (m_hold == 0) begin ph = 8; m_done = 1'b1; end
             else m_hold = m_hold - 1;
          8: if (done_ack) ph = 0;
          default: ph = 0;
        endcase
      end
      s2 = s1;
      s1 = trig;
    end
  end

  function automatic logic [1:0] exp_code(int p);
    if (p == 5 || p == 7) return 2'b10;
    if (p == 6) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-cycle comparison, parameter pin driving and watchdog
  always @(negedge clk) begin
    cyc++;
    check(glitch_out == exp_code(ph), "R4 glitch_out vs model", glitch_out, exp_code(ph));
    check(busy == (ph != 0), "R9 busy vs model", busy, ph != 0);
    check(done == m_done, "R6/R7 done vs model", done, m_done);
    check(param_ready == (ph == 0 || ph == 1 || ph == 4), "R1 param_ready vs model",
          param_ready, (ph == 0 || ph == 1 || ph == 4));
    param_valid = (q.size() > 0);
    param_data  = (q.size() > 0) ? q[0] : 32'h0;
    if (cyc > 150000) begin
      check(1'b0, "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig_edge();
    trig = 1'b0; tick(3);
    trig = 1'b1; tick(3);
  endtask

  int pre10, n11, post10;
  task automatic run_to_done();
    bit seen11;
    pre10 = 0; n11 = 0; post10 = 0; seen11 = 0;
    for (int g = 0; g < 20000 && !done; g++) begin
      @(negedge clk);
      #1;
      if (glitch_out == 2'b11) begin n11++; seen11 = 1; end
      else if (glitch_out == 2'b10) begin
        if (seen11) post10++; else pre10++;
      end
    end
  endtask

  task automatic ack();
    done_ack = 1'b1; tick(1); done_ack = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    check(glitch_out == 2'b00, "R4 reset output", glitch_out, 0);
    check(!busy, "R9 reset busy", busy, 0);
    check(!done, "R6 reset done", done, 0);
    check(param_ready, "R1 reset ready", param_ready, 1);

    // trigger already high at start; edge count 2, offset 3
    trig = 1'b1;
    q.push_back(32'd2);
    q.push_back(32'd3);
    tick(8);
    check(!param_ready, "R1 no ready while counting", param_ready, 0);
    check(glitch_out == 2'b00, "R2 high level not an edge", glitch_out, 0);
    trig_edge();
    trig_edge();
    tick(4);
    check(glitch_out == 2'b00, "R3 two of three edges", glitch_out, 0);
    trig_edge();
    tick(10);
    check(glitch_out == 2'b00, "R8 stalled without width", glitch_out, 0);
    check(param_ready, "R8 waiting for width", param_ready, 1);
    check(busy, "R9 busy while stalled", busy, 1);
    q.push_back(32'd4);
    run_to_done();
    check(pre10 == 4, "R3 offset cycles", pre10, 4);
    check(n11 == 5, "R3 width cycles", n11, 5);
    check(post10 == HOLD, "R5 hold cycles", post10, HOLD);
    #1;
    check(glitch_out == 2'b00, "R6 rest at done", glitch_out, 0);
    tick(5);
    check(done && busy && !param_ready, "R6 waits for ack", {done, busy, param_ready}, 3'b110);
    ack();
    check(param_ready && !busy, "R6 ready after ack", {param_ready, busy}, 2'b10);
    check(done, "R7 done sticky after ack", done, 1);
    q.push_back(32'd0);
    tick(3);
    check(done, "R7 done kept after edge count", done, 1);
    q.push_back(32'd0);
    tick(3);
    check(!done, "R7 done cleared by offset", done, 0);

    // width queued early; latency from final edge
    q.push_back(32'd0);
    tick(4);
    check(!param_ready && q.size() == 1, "R1 width held during counting", q.size(), 1);
    trig = 1'b0; tick(4);
    trig = 1'b1;
    tick(3);
    check(glitch_out == 2'b00, "R11 before latency", glitch_out, 0);
    tick(1);
    check(glitch_out == 2'b10, "R11 offset after four edges", glitch_out, 2);
    run_to_done();
    check(n11 == 1 && post10 == HOLD, "R3 single width cycle", n11, 1);
    ack();

    // abort during offset
    q.push_back(32'd0);
    q.push_back(32'd100);
    tick(3);
    trig_edge();
    q.push_back(32'd50);
    tick(6);
    check(glitch_out == 2'b10, "R10 in offset before abort", glitch_out, 2);
    abort = 1'b1; tick(1); abort = 1'b0;
    check(glitch_out == 2'b00 && !busy && !done, "R10 abort to rest",
          {glitch_out, busy, done}, 0);
    tick(20);
    check(glitch_out == 2'b00, "R10 stays at rest", glitch_out, 0);
    finish_run();
  end
endmodule